// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block drives the enable pins of a set of power rails and decides, rail by rail, when each one comes up and goes down. A rail may start from any mix of four sources: the global control pin, a soft on/off command level, a general-purpose input matching a configured level, and a set of parent rails that must all be in regulation. Once its start condition holds, the rail waits a programmed number of millisecond ticks before asserting its enable. It then waits, within a turn-on time limit, for its voltage to be reported good. Turn-off mirrors this. The rail waits for its off-dependency rails to leave regulation and then for its own turn-off delay.

Voltage status comes from two comparator inputs per rail, one above the power-good-on level and one below the power-good-off level, and the block applies hysteresis between them. A rail without a voltage monitor is judged purely by elapsed time. A rail that misses its turn-on limit enters a fault state. The fault starts shutdowns on the rails it lists as shutdown slaves, either delayed or immediate per slave. The millisecond time base arrives as a one-cycle strobe, so the whole block scales with the strobe period.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and right after reset every rail is in state OFF, every enable is low and no fault flag is set.
- R2: A rail leaves OFF when its start condition holds. Each selected source must agree: the command level if selected, the control pin if selected, and input gpi[sel] equal to the configured level if the input gate is selected. Unselected sources are ignored.
- R3: A rail stays in WAIT_DEP_ON while any rail in its on-dependency mask is not in regulation; its own mask bit is ignored.
- R4: After the dependencies are met, a rail counts ms_tick strobes in DELAY_ON. The clock edge after the count reaches the turn-on delay moves it to RAMP_ON, and only then does the enable rise.
- R5: A monitored rail still not good after its turn-on limit (non-zero) of ticks in RAMP_ON enters FAULT, drops its enable and raises its fault flag. It leaves FAULT only when its start condition is removed. A limit of zero waits forever.
- R6: A monitored rail's good flag is set by the above-on input, cleared by the below-off input, and holds its value while neither is active.
- R7: An unmonitored rail is reported good once its turn-on limit has elapsed in RAMP_ON. After it returns to OFF it is reported not good once the turn-off warning limit of ticks has elapsed.
- R8: When the start condition is removed, a rail with its enable high waits in WAIT_DEP_OFF until every rail in its off-dependency mask is out of regulation. It then counts the turn-off delay in DELAY_OFF and returns to OFF with its enable low.
- R9: When a rail enters FAULT, each of its shutdown slaves that holds its enable high enters DELAY_OFF on the next clock edge, unless that slave is set for immediate shutdown. A slave shut down this way stays in OFF until its own start condition is removed.
- R10: A slave set for immediate shutdown drops its enable on the clock edge after its master's fault flag first appears.
- R11: With auto-enable set, a rail ignores both the command level and the control pin.
- R12: A rail set to monitor-only never leaves OFF and never drives its enable.
- R13: Each rail's state appears on rail_state as a 3-bit code: OFF=0, WAIT_DEP_ON=1, DELAY_ON=2, RAMP_ON=3, ON=4, WAIT_DEP_OFF=5, DELAY_OFF=6, FAULT=7. The enable is high exactly in codes 3 to 6, and the fault flag is high exactly in code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| ctrl_pin | input | 1 | Global control pin level |
| soft_cmd | input | 1 | Soft on (1) / off (0) command level |
| gpi | input | GPI_W | General-purpose start inputs |
| v_above_on | input | NUM_RAILS | Rail voltage above power-good-on level |
| v_below_off | input | NUM_RAILS | Rail voltage below power-good-off level |
| cfg_src_cmd | input | NUM_RAILS | Rail obeys the command level |
| cfg_src_pin | input | NUM_RAILS | Rail obeys the control pin |
| cfg_auto | input | NUM_RAILS | Auto-enable: ignore command and pin |
| cfg_gpi_en | input | NUM_RAILS | Rail is gated by a selected input |
| cfg_gpi_lvl | input | NUM_RAILS | Required level of the selected input |
| cfg_gpi_sel | input | NUM_RAILS*GSEL_W | Input index per rail |
| cfg_on_mask | input | NUM_RAILS*NUM_RAILS | Row i: on-dependency parents of rail i |
| cfg_off_mask | input | NUM_RAILS*NUM_RAILS | Row i: off-dependency rails of rail i |
| cfg_slave_mask | input | NUM_RAILS*NUM_RAILS | Row i: shutdown slaves of rail i |
| cfg_mon_only | input | NUM_RAILS | Monitor-only rail |
| cfg_has_vmon | input | NUM_RAILS | Rail has a voltage monitor |
| cfg_imm_off | input | NUM_RAILS | Immediate shutdown on master fault |
| cfg_ton_dly | input | NUM_RAILS*DLY_W | Turn-on delay in ticks |
| cfg_ton_max | input | NUM_RAILS*DLY_W | Turn-on limit in ticks (0 = none) |
| cfg_toff_dly | input | NUM_RAILS*DLY_W | Turn-off delay in ticks |
| cfg_toff_warn | input | NUM_RAILS*DLY_W | Turn-off settle limit in ticks |
| rail_en | output | NUM_RAILS | Rail enables |
| rail_good | output | NUM_RAILS | Rail in regulation |
| rail_fault | output | NUM_RAILS | Rail in fault |
| rail_state | output | NUM_RAILS*3 | Per-rail state code |

## Verification
The assertions assume the configuration inputs are held constant outside reset and that ms_tick is a single-cycle strobe. They also assume the two comparator inputs of a rail are never active together. The bench changes configuration only while reset is asserted and emits the tick every fourth clock. Its rail plant ramps a level up while the enable is high and down while it is low, and reports above-on and below-off from disjoint bands of that level. Any forced comparator values it applies are never both high.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   localparam int ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_OFF          = 3'd0,
      ST_WAIT_DEP_ON  = 3'd1,
      ST_DELAY_ON     = 3'd2,
      ST_RAMP_ON      = 3'd3,
      ST_ON           = 3'd4,
      ST_WAIT_DEP_OFF = 3'd5,
      ST_DELAY_OFF    = 3'd6,
      ST_FAULT        = 3'd7
   } rail_st_e;
endpackage

// File: rtl/pwr_pg_hyst.sv
module pwr_pg_hyst (
   input  logic clk,
   input  logic rst_n,
   input  logic above_on,
   input  logic below_off,
   output logic good
);
   always_ff @(posedge clk) begin
      if (!rst_n)         good <= 1'b0;
      else if (above_on)  good <= 1'b1;
      else if (below_off) good <= 1'b0;
   end

   p_good_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      above_on |=> good);
   p_good_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!above_on && !below_off) |=> $stable(good));
endmodule

// File: rtl/pwr_rail_gate.sv
module pwr_rail_gate #(
   parameter int N      = 10,
   parameter int IDX    = 0,
   parameter int GPI_W  = 4,
   parameter int GSEL_W = 2
) (
   input  logic [N-1:0]      all_good,
   input  logic [N-1:0]      on_mask,
   input  logic [N-1:0]      off_mask,
   input  logic [N-1:0]      master_col,
   input  logic [N-1:0]      flt_new,
   input  logic              src_cmd,
   input  logic              src_pin,
   input  logic              auto_en,
   input  logic              gpi_en,
   input  logic              gpi_lvl,
   input  logic [GSEL_W-1:0] gpi_sel,
   input  logic [GPI_W-1:0]  gpi,
   input  logic              soft_cmd,
   input  logic              ctrl_pin,
   output logic              cmd_ok,
   output logic              dep_on_ok,
   output logic              dep_off_ok,
   output logic              shut_req
);
   localparam logic [N-1:0] SELF  = N'(1) << IDX;
   localparam logic [N-1:0] OTHER = ~SELF;

   logic gpi_bit;
   logic src_ok;

   generate
      if (GPI_W == 1) begin : g_one_gpi
         assign gpi_bit = gpi[0] ^ (|gpi_sel & 1'b0);
      end else begin : g_sel_gpi
         assign gpi_bit = gpi[gpi_sel];
      end
   endgenerate

   assign src_ok     = auto_en | ((~src_cmd | soft_cmd) & (~src_pin | ctrl_pin));
   assign cmd_ok     = src_ok & (~gpi_en | (gpi_bit == gpi_lvl));
   assign dep_on_ok  = &(all_good | ~(on_mask & OTHER));
   assign dep_off_ok = &(~all_good | ~(off_mask & OTHER));
   assign shut_req   = |(flt_new & master_col & OTHER);
endmodule

// File: rtl/pwr_rail_fsm.sv
module pwr_rail_fsm
   import pwr_seq_pkg::*;
#(
   parameter int DLY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_ok,
   input  logic             dep_on_ok,
   input  logic             dep_off_ok,
   input  logic             shut_req,
   input  logic             v_good,
   input  logic             mon_only,
   input  logic             has_vmon,
   input  logic             imm_off,
   input  logic [DLY_W-1:0] ton_dly,
   input  logic [DLY_W-1:0] ton_max,
   input  logic [DLY_W-1:0] toff_dly,
   input  logic [DLY_W-1:0] toff_warn,
   output rail_st_e         state,
   output logic             en,
   output logic             good,
   output logic             fault,
   output logic             flt_new
);
   localparam logic [DLY_W-1:0] CNT_TOP = '1;

   rail_st_e         st_n;
   logic [DLY_W-1:0] cnt, cnt_n, cnt_inc;
   logic             blocked, blocked_n;
   logic             good_nv, good_nv_n;
   rail_st_e         drop_st;

   assign cnt_inc = (tick && cnt != CNT_TOP) ? cnt + 1'b1 : cnt;
   assign drop_st = imm_off ? ST_OFF : ST_DELAY_OFF;

   always_comb begin
      st_n  = state;
      cnt_n = cnt_inc;
      unique case (state)
         ST_OFF: begin
            if (!mon_only && cmd_ok && !blocked) st_n = ST_WAIT_DEP_ON;
         end
         ST_WAIT_DEP_ON: begin
            if (shut_req || !cmd_ok) begin
               st_n = ST_OFF; cnt_n = '0;
            end else if (dep_on_ok) begin
               st_n = ST_DELAY_ON; cnt_n = '0;
            end
         end
         ST_DELAY_ON: begin
            if (shut_req || !cmd_ok) begin
               st_n = ST_OFF; cnt_n = '0;
            end else if (cnt >= ton_dly) begin
               st_n = ST_RAMP_ON; cnt_n = '0;
            end
         end
         ST_RAMP_ON: begin
            if (shut_req) begin
               st_n = drop_st; cnt_n = '0;
            end else if (!cmd_ok) begin
               st_n = ST_WAIT_DEP_OFF;
            end else if (has_vmon) begin
               if (v_good) st_n = ST_ON;
               else if (ton_max != '0 && cnt >= ton_max) begin
                  st_n = ST_FAULT; cnt_n = '0;
               end
            end else if (cnt >= ton_max) begin
               st_n = ST_ON;
            end
         end
         ST_ON: begin
            if (shut_req) begin
               st_n = drop_st; cnt_n = '0;
            end else if (!cmd_ok) begin
               st_n = ST_WAIT_DEP_OFF;
            end
         end
         ST_WAIT_DEP_OFF: begin
            if (shut_req) begin
               st_n = drop_st; cnt_n = '0;
            end else if (dep_off_ok) begin
               st_n = ST_DELAY_OFF; cnt_n = '0;
            end
         end
         ST_DELAY_OFF: begin
            if ((shut_req && imm_off) || cnt >= toff_dly) begin
               st_n = ST_OFF; cnt_n = '0;
            end
         end
         ST_FAULT: begin
            if (!cmd_ok) begin
               st_n = ST_OFF; cnt_n = '0;
            end
         end
         default: begin
            st_n = ST_OFF; cnt_n = '0;
         end
      endcase
   end

   always_comb begin
      if (!cmd_ok)                          blocked_n = 1'b0;
      else if (shut_req || st_n == ST_FAULT) blocked_n = 1'b1;
      else                                  blocked_n = blocked;
   end

   always_comb begin
      if (st_n == ST_ON) good_nv_n = 1'b1;
      else if ((state == ST_OFF || state == ST_FAULT) && cnt >= toff_warn) good_nv_n = 1'b0;
      else good_nv_n = good_nv;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_OFF;
         cnt     <= '0;
         blocked <= 1'b0;
         good_nv <= 1'b0;
         flt_new <= 1'b0;
      end else begin
         state   <= st_n;
         cnt     <= cnt_n;
         blocked <= blocked_n;
         good_nv <= good_nv_n;
         flt_new <= (st_n == ST_FAULT) && (state != ST_FAULT);
      end
   end

   assign en    = (state == ST_RAMP_ON) || (state == ST_ON) ||
                  (state == ST_WAIT_DEP_OFF) || (state == ST_DELAY_OFF);
   assign fault = (state == ST_FAULT);
   assign good  = has_vmon ? v_good : good_nv;

   p_mon_only_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_only && state == ST_OFF) |=> (state == ST_OFF && !en));
   p_imm_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (shut_req && imm_off && en) |=> !en);
   p_fault_from_ramp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(state) == ST_RAMP_ON);
   p_en_after_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> $past(state) == ST_DELAY_ON);
   p_wait_parents_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_DEP_ON && !dep_on_ok && cmd_ok && !shut_req) |=> state == ST_WAIT_DEP_ON);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_seq_pkg::*;
#(
   parameter int NUM_RAILS = 10,
   parameter int DLY_W     = 12,
   parameter int GPI_W     = 4,
   localparam int GSEL_W   = (GPI_W > 1) ? $clog2(GPI_W) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ms_tick,
   input  logic                           ctrl_pin,
   input  logic                           soft_cmd,
   input  logic [GPI_W-1:0]               gpi,
   input  logic [NUM_RAILS-1:0]           v_above_on,
   input  logic [NUM_RAILS-1:0]           v_below_off,
   input  logic [NUM_RAILS-1:0]           cfg_src_cmd,
   input  logic [NUM_RAILS-1:0]           cfg_src_pin,
   input  logic [NUM_RAILS-1:0]           cfg_auto,
   input  logic [NUM_RAILS-1:0]           cfg_gpi_en,
   input  logic [NUM_RAILS-1:0]           cfg_gpi_lvl,
   input  logic [NUM_RAILS*GSEL_W-1:0]    cfg_gpi_sel,
   input  logic [NUM_RAILS*NUM_RAILS-1:0] cfg_on_mask,
   input  logic [NUM_RAILS*NUM_RAILS-1:0] cfg_off_mask,
   input  logic [NUM_RAILS*NUM_RAILS-1:0] cfg_slave_mask,
   input  logic [NUM_RAILS-1:0]           cfg_mon_only,
   input  logic [NUM_RAILS-1:0]           cfg_has_vmon,
   input  logic [NUM_RAILS-1:0]           cfg_imm_off,
   input  logic [NUM_RAILS*DLY_W-1:0]     cfg_ton_dly,
   input  logic [NUM_RAILS*DLY_W-1:0]     cfg_ton_max,
   input  logic [NUM_RAILS*DLY_W-1:0]     cfg_toff_dly,
   input  logic [NUM_RAILS*DLY_W-1:0]     cfg_toff_warn,
   output logic [NUM_RAILS-1:0]           rail_en,
   output logic [NUM_RAILS-1:0]           rail_good,
   output logic [NUM_RAILS-1:0]           rail_fault,
   output logic [NUM_RAILS*ST_W-1:0]      rail_state
);
   initial begin
      assert (NUM_RAILS >= 1 && NUM_RAILS <= 10)
         else $error("NUM_RAILS must be 1..10");
      assert (DLY_W >= 12) else $error("DLY_W must hold 3276 ms");
      assert (GPI_W >= 1) else $error("GPI_W must be at least 1");
   end

   logic [NUM_RAILS-1:0] flt_new;

   genvar gi, gk;
   generate
      for (gi = 0; gi < NUM_RAILS; gi++) begin : g_rail
         logic [NUM_RAILS-1:0] master_col;
         logic     cmd_ok, dep_on_ok, dep_off_ok, shut_req, v_good;
         rail_st_e st;

         for (gk = 0; gk < NUM_RAILS; gk++) begin : g_col
            assign master_col[gk] = cfg_slave_mask[gk*NUM_RAILS + gi];
         end

         pwr_rail_gate #(
            .N(NUM_RAILS), .IDX(gi), .GPI_W(GPI_W), .GSEL_W(GSEL_W)
         ) u_gate (
            .all_good   (rail_good),
            .on_mask    (cfg_on_mask[gi*NUM_RAILS +: NUM_RAILS]),
            .off_mask   (cfg_off_mask[gi*NUM_RAILS +: NUM_RAILS]),
            .master_col (master_col),
            .flt_new    (flt_new),
            .src_cmd    (cfg_src_cmd[gi]),
            .src_pin    (cfg_src_pin[gi]),
            .auto_en    (cfg_auto[gi]),
            .gpi_en     (cfg_gpi_en[gi]),
            .gpi_lvl    (cfg_gpi_lvl[gi]),
            .gpi_sel    (cfg_gpi_sel[gi*GSEL_W +: GSEL_W]),
            .gpi        (gpi),
            .soft_cmd   (soft_cmd),
            .ctrl_pin   (ctrl_pin),
            .cmd_ok     (cmd_ok),
            .dep_on_ok  (dep_on_ok),
            .dep_off_ok (dep_off_ok),
            .shut_req   (shut_req)
         );

         pwr_pg_hyst u_hyst (
            .clk       (clk),
            .rst_n     (rst_n),
            .above_on  (v_above_on[gi]),
            .below_off (v_below_off[gi]),
            .good      (v_good)
         );

         pwr_rail_fsm #(.DLY_W(DLY_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (ms_tick),
            .cmd_ok     (cmd_ok),
            .dep_on_ok  (dep_on_ok),
            .dep_off_ok (dep_off_ok),
            .shut_req   (shut_req),
            .v_good     (v_good),
            .mon_only   (cfg_mon_only[gi]),
            .has_vmon   (cfg_has_vmon[gi]),
            .imm_off    (cfg_imm_off[gi]),
            .ton_dly    (cfg_ton_dly[gi*DLY_W +: DLY_W]),
            .ton_max    (cfg_ton_max[gi*DLY_W +: DLY_W]),
            .toff_dly   (cfg_toff_dly[gi*DLY_W +: DLY_W]),
            .toff_warn  (cfg_toff_warn[gi*DLY_W +: DLY_W]),
            .state      (st),
            .en         (rail_en[gi]),
            .good       (rail_good[gi]),
            .fault      (rail_fault[gi]),
            .flt_new    (flt_new[gi])
         );

         assign rail_state[gi*ST_W +: ST_W] = st;
      end
   endgenerate

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (rail_en == '0 && rail_fault == '0));
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
   localparam int N  = 4;
   localparam int DW = 12;
   localparam int GW = 4;
   localparam int GS = 2;

   logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, ctrl_pin = 1'b0, soft_cmd = 1'b0;
   logic [GW-1:0] gpi = '0;
   logic [N-1:0]  v_above_on = '0, v_below_off = '1;
   logic [N-1:0]  c_cmd, c_pin, c_auto, c_gen, c_glvl, c_mon, c_vmon, c_imm;
   logic [N*GS-1:0] c_gsel;
   logic [N*N-1:0]  c_onm, c_offm, c_slv;
   logic [N*DW-1:0] c_ton, c_tmax, c_toff, c_twarn;
   logic [N-1:0]  rail_en, rail_good, rail_fault;
   logic [N*3-1:0] rail_state;

   int n_chk = 0, n_fail = 0, cyc = 0, div = 0;
   bit cmp_on = 0;
   int lvl [N];
   bit stuck [N], ovr [N], ovr_on [N], ovr_off [N];
   int m_st [N], m_cnt [N];
   bit m_blk [N], m_fn [N], m_gv [N], m_gnv [N];

   pwr_seq_ctrl #(.NUM_RAILS(N), .DLY_W(DW), .GPI_W(GW)) u_pwr_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ctrl_pin(ctrl_pin), .soft_cmd(soft_cmd),
      .gpi(gpi), .v_above_on(v_above_on), .v_below_off(v_below_off),
      .cfg_src_cmd(c_cmd), .cfg_src_pin(c_pin), .cfg_auto(c_auto), .cfg_gpi_en(c_gen),
      .cfg_gpi_lvl(c_glvl), .cfg_gpi_sel(c_gsel), .cfg_on_mask(c_onm), .cfg_off_mask(c_offm),
      .cfg_slave_mask(c_slv), .cfg_mon_only(c_mon), .cfg_has_vmon(c_vmon), .cfg_imm_off(c_imm),
      .cfg_ton_dly(c_ton), .cfg_ton_max(c_tmax), .cfg_toff_dly(c_toff), .cfg_toff_warn(c_twarn),
      .rail_en(rail_en), .rail_good(rail_good), .rail_fault(rail_fault), .rail_state(rail_state));

   always #5 clk = ~clk;

   function automatic int fld(input logic [N*DW-1:0] v, input int i);
      return int'(v[i*DW +: DW]);
   endfunction

   function automatic int st_of(input int i);
      return int'(rail_state[i*3 +: 3]);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // tick strobe and rail plant, driven away from the active edge
   always @(negedge clk) begin
      div++;
      ms_tick <= (div % 4 == 0);
      for (int i = 0; i < N; i++) begin
         if (rail_en[i]) lvl[i] = (lvl[i] < 20) ? lvl[i] + 1 : 20;
         else            lvl[i] = (lvl[i] > 0) ? lvl[i] - 1 : 0;
         v_above_on[i]  <= ovr[i] ? ovr_on[i]  : (lvl[i] >= 12 && !stuck[i]);
         v_below_off[i] <= ovr[i] ? ovr_off[i] : (lvl[i] <= 4);
      end
   end

   // behavioural reference model, one update per clock
   always @(posedge clk) begin
      int o_st [N], o_cnt [N];
      bit o_blk [N], o_fn [N], o_gd [N];
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_blk[i] = 0; m_fn[i] = 0; m_gv[i] = 0; m_gnv[i] = 0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            o_st[i] = m_st[i]; o_cnt[i] = m_cnt[i]; o_blk[i] = m_blk[i]; o_fn[i] = m_fn[i];
            o_gd[i] = c_vmon[i] ? m_gv[i] : m_gnv[i];
         end
         for (int i = 0; i < N; i++) begin
            bit src, cok, don, doff, shut, gmatch;
            int nst, ncnt, dd;
            gmatch = (gpi[c_gsel[i*GS +: GS]] == c_glvl[i]);
            src  = c_auto[i] || ((!c_cmd[i] || soft_cmd) && (!c_pin[i] || ctrl_pin));
            cok  = src && (!c_gen[i] || gmatch);
            don = 1; doff = 1; shut = 0;
            for (int k = 0; k < N; k++) if (k != i) begin
               if (c_onm[i*N + k] && !o_gd[k]) don = 0;
               if (c_offm[i*N + k] && o_gd[k]) doff = 0;
               if (c_slv[k*N + i] && o_fn[k]) shut = 1;
            end
            nst  = o_st[i];
            ncnt = (ms_tick && o_cnt[i] < 4095) ? o_cnt[i] + 1 : o_cnt[i];
            dd   = c_imm[i] ? 0 : 6;
            case (o_st[i])
               0: if (!c_mon[i] && cok && !o_blk[i]) nst = 1;
               1: if (shut || !cok) begin nst = 0; ncnt = 0; end
                  else if (don) begin nst = 2; ncnt = 0; end
               2: if (shut || !cok) begin nst = 0; ncnt = 0; end
                  else if (o_cnt[i] >= fld(c_ton, i)) begin nst = 3; ncnt = 0; end
               3: if (shut) begin nst = dd; ncnt = 0; end
                  else if (!cok) nst = 5;
                  else if (c_vmon[i]) begin
                     if (m_gv[i]) nst = 4;
                     else if (fld(c_tmax, i) != 0 && o_cnt[i] >= fld(c_tmax, i)) begin nst = 7; ncnt = 0; end
                  end else if (o_cnt[i] >= fld(c_tmax, i)) nst = 4;
               4: if (shut) begin nst = dd; ncnt = 0; end
                  else if (!cok) nst = 5;
               5: if (shut) begin nst = dd; ncnt = 0; end
                  else if (doff) begin nst = 6; ncnt = 0; end
               6: if ((shut && c_imm[i]) || o_cnt[i] >= fld(c_toff, i)) begin nst = 0; ncnt = 0; end
               default: if (!cok) begin nst = 0; ncnt = 0; end
            endcase
            if (!cok) m_blk[i] = 0;
            else if (shut || nst == 7) m_blk[i] = 1;
            if (nst == 4) m_gnv[i] = 1;
            else if ((o_st[i] == 0 || o_st[i] == 7) && o_cnt[i] >= fld(c_twarn, i)) m_gnv[i] = 0;
            if (v_above_on[i]) m_gv[i] = 1;
            else if (v_below_off[i]) m_gv[i] = 0;
            m_fn[i]  = (nst == 7 && o_st[i] != 7);
            m_st[i]  = nst;
            m_cnt[i] = ncnt;
         end
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         for (int i = 0; i < N; i++) begin
            bit e_en, e_gd;
            e_en = (m_st[i] >= 3 && m_st[i] <= 6);
            e_gd = c_vmon[i] ? m_gv[i] : m_gnv[i];
            chk(st_of(i) == m_st[i], "R13 state code vs model", st_of(i), m_st[i]);
            chk(rail_en[i] == e_en, "R4 enable vs model", rail_en[i], e_en);
            chk(rail_fault[i] == (m_st[i] == 7), "R5 fault flag vs model", rail_fault[i], m_st[i] == 7);
            chk(rail_good[i] == e_gd, "R6 good flag vs model", rail_good[i], e_gd);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         finish_run();
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin stuck[i] = 0; ovr[i] = 0; ovr_on[i] = 0; ovr_off[i] = 0; end
   endtask

   task automatic set_dly(input int i, input int ton, input int tmax, input int toff, input int twarn);
      c_ton[i*DW +: DW] = DW'(ton);  c_tmax[i*DW +: DW] = DW'(tmax);
      c_toff[i*DW +: DW] = DW'(toff); c_twarn[i*DW +: DW] = DW'(twarn);
   endtask

   task automatic clear_cfg();
      c_cmd = '0; c_pin = '0; c_auto = '0; c_gen = '0; c_glvl = '0; c_mon = '0;
      c_vmon = '0; c_imm = '0; c_gsel = '0; c_onm = '0; c_offm = '0; c_slv = '0;
      c_ton = '0; c_tmax = '0; c_toff = '0; c_twarn = '0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) lvl[i] = 0;
      clear_cfg();
      do_reset();
      // configuration A: rail1 waits for rail0, rail0 waits for rail1 to go off
      c_pin = 4'b1111; c_vmon = 4'b1011; c_mon = 4'b1000; c_imm = 4'b0100;
      c_onm[1*N + 0] = 1'b1; c_offm[0*N + 1] = 1'b1; c_slv[0*N + 2] = 1'b1;
      set_dly(0, 3, 8, 2, 0); set_dly(1, 2, 8, 1, 0); set_dly(2, 1, 3, 1, 2); set_dly(3, 1, 4, 1, 0);
      wait_cyc(4);
      rst_n = 1'b1; cmp_on = 1;
      wait_cyc(1);
      chk(rail_en == '0, "R1 enables after reset", rail_en, 0);
      chk(rail_state == '0, "R1 states after reset", rail_state, 0);
      chk(rail_fault == '0, "R1 faults after reset", rail_fault, 0);

      ctrl_pin = 1'b1;
      wait_cyc(5);
      chk(st_of(1) == 1, "R3 child waits for parent", st_of(1), 1);
      chk(st_of(0) == 2, "R4 parent counting delay", st_of(0), 2);
      chk(rail_en[0] == 0, "R4 enable low during delay", rail_en[0], 0);
      wait_cyc(400);
      for (int i = 0; i < 3; i++) chk(st_of(i) == 4, "R2 pin start reaches ON", st_of(i), 4);
      chk(st_of(3) == 0 && rail_en[3] == 0, "R12 monitor-only stays off", st_of(3), 0);
      chk(rail_good[2] == 1, "R7 unmonitored rail good", rail_good[2], 1);

      ctrl_pin = 1'b0;
      wait_cyc(6);
      chk(st_of(0) == 5 && rail_en[0] == 1, "R8 waits on off-dependency", st_of(0), 5);
      wait_cyc(400);
      chk(rail_state == '0 && rail_en == '0, "R8 all rails off", rail_state, 0);
      chk(rail_good[2] == 0, "R7 unmonitored rail not good after settle", rail_good[2], 0);

      // fault on rail0, rail2 is an immediate slave
      stuck[0] = 1; ctrl_pin = 1'b1;
      for (int w = 0; w < 2000 && !rail_fault[0]; w++) wait_cyc(1);
      chk(rail_fault[0] == 1 && rail_en[0] == 0, "R5 turn-on fault raised", rail_fault[0], 1);
      chk(rail_en[2] == 1, "R10 slave enable before reaction", rail_en[2], 1);
      wait_cyc(1);
      chk(rail_en[2] == 0, "R10 slave enable dropped next edge", rail_en[2], 0);
      wait_cyc(100);
      chk(st_of(2) == 0 && st_of(0) == 7, "R9 slave held off while commanded", st_of(2), 0);
      ctrl_pin = 1'b0; stuck[0] = 0;
      wait_cyc(200);
      chk(rail_fault == '0 && rail_state == '0, "R5 fault clears on command removal", rail_fault, 0);
      ctrl_pin = 1'b1;
      wait_cyc(400);
      chk(st_of(2) == 4, "R9 slave restarts after release", st_of(2), 4);
      ctrl_pin = 1'b0;
      wait_cyc(400);

      // configuration C: input gating, auto-enable, zero limit, delayed slave
      cmp_on = 0; do_reset(); clear_cfg();
      c_gen = 4'b1011; c_glvl = 4'b1010;
      c_gsel[0*GS +: GS] = 2'd1; c_gsel[1*GS +: GS] = 2'd0; c_gsel[3*GS +: GS] = 2'd2;
      c_cmd = 4'b0110; c_pin = 4'b0100; c_auto = 4'b0100; c_vmon = 4'b1111;
      c_slv[1*N + 3] = 1'b1;
      set_dly(0, 1, 0, 1, 0); set_dly(1, 1, 4, 1, 0); set_dly(2, 1, 0, 1, 0); set_dly(3, 1, 8, 5, 0);
      stuck[0] = 1; soft_cmd = 1'b0; ctrl_pin = 1'b0; gpi = 4'b0100;
      wait_cyc(4);
      rst_n = 1'b1; cmp_on = 1;
      wait_cyc(300);
      chk(st_of(2) == 4, "R11 auto rail ignores command and pin", st_of(2), 4);
      chk(st_of(0) == 3 && rail_fault[0] == 0, "R5 zero limit waits forever", st_of(0), 3);
      chk(st_of(3) == 4, "R2 input-gated rail started", st_of(3), 4);
      chk(st_of(1) == 0, "R2 command low keeps rail off", st_of(1), 0);
      soft_cmd = 1'b1;
      wait_cyc(50);
      chk(st_of(1) == 0, "R2 input mismatch keeps rail off", st_of(1), 0);

      ovr[2] = 1; ovr_on[2] = 0; ovr_off[2] = 0;
      wait_cyc(20);
      chk(rail_good[2] == 1, "R6 good holds between levels", rail_good[2], 1);
      ovr_off[2] = 1;
      wait_cyc(2);
      chk(rail_good[2] == 0, "R6 good cleared below off level", rail_good[2], 0);
      ovr_off[2] = 0; ovr_on[2] = 1;
      wait_cyc(2);
      chk(rail_good[2] == 1, "R6 good set above on level", rail_good[2], 1);

      stuck[1] = 1; gpi[0] = 1'b1;
      for (int w = 0; w < 2000 && !rail_fault[1]; w++) wait_cyc(1);
      chk(rail_fault[1] == 1, "R5 second master faults", rail_fault[1], 1);
      wait_cyc(1);
      chk(st_of(3) == 6 && rail_en[3] == 1, "R9 delayed slave in turn-off delay", st_of(3), 6);
      wait_cyc(100);
      chk(st_of(3) == 0 && rail_en[3] == 0, "R9 delayed slave off", st_of(3), 0);

      finish_run();
   end
endmodule